// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits behind a byte-wide register bus. Software writes a shared output data register and sets, pin by pin, whether the output stage pushes and pulls or only sinks current. A further register selects the low-voltage level on the pins that offer it. Each pin also has its own control byte that puts it in input, output or high-impedance mode and turns on a pull-up or a pull-down. The pad levels go through a two-flop synchronizer. A read-only mirror register returns those synchronized levels, which need not match the output data register.

Bus accesses take one cycle. A write is taken on the rising edge when the write strobe is high. Read data is a combinational function of the address. The pad side gets one output-enable, one output value, one pull-up request, one pull-down request and one low-voltage select per pin. The register offsets are 0 for output data, 1 for the mirror, 2 for output type and 3 for voltage select. The per-pin control bytes start at 8, so pin `i` is at 8+i. Offsets 4 to 7 are unmapped.

The control byte uses bit 0 for input mode, bit 1 for output mode, bit 2 for pull-up, bit 3 for pull-down and bit 7 for high impedance. Bits 6 to 4 always read as zero. The parameter `TRI_CAP` marks the pins that accept high impedance, and `VSEL_CAP` marks the pins that have a voltage select.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A synchronous reset clears the output data, output-type and voltage-select registers to 0x00 and sets every control byte to 0x01 (input mode, no pulls).
- R2: The output data register (offset 0) reads back the value last written. A pin whose control byte has bit 1 set and whose output-type bit is 0 drives `pad_oe`=1 and `pad_out` equal to its data bit.
- R3: Reading offset 1 returns the pad levels delayed by two clock edges, not the output data register. A pad change is not visible after one edge and is visible after the second.
- R4: When a pin's bit in the output-type register (offset 2) is 1, the pin drives `pad_out`=0. In output mode it asserts `pad_oe` only while its data bit is 0.
- R5: A control-byte write stores only bits 3..0. If bits 1 and 0 are both written as 1, output mode wins and bit 0 reads 0. If bits 2 and 3 are both written as 1, the pull-up wins and bit 3 reads 0. Bits 6..4 read 0.
- R6: Writing a control byte with bit 7 set stores exactly 0x80 on a pin marked in `TRI_CAP`, and that pin drives neither output nor pulls. On any other pin the write stores 0x01 instead.
- R7: Writing the output data register while a pin is in input mode leaves `pad_oe` low. The written level appears on `pad_out` once the pin is switched to output mode.
- R8: A 1 in the voltage-select register (offset 3) raises `pad_lowv` for that pin. Bits of pins not in `VSEL_CAP` are never stored and read 0.
- R9: Reads of offsets 4 to 7 return 0x00. Writes to the mirror offset or to an unmapped offset change no register.
- R10: `pad_pu` and `pad_pd` follow bits 2 and 3 of each pin's stored control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pad_in | input | NPINS | Raw pad levels |
| pad_oe | output | NPINS | Per-pin output enable |
| pad_out | output | NPINS | Per-pin output value |
| pad_pu | output | NPINS | Per-pin pull-up request |
| pad_pd | output | NPINS | Per-pin pull-down request |
| pad_lowv | output | NPINS | Per-pin low-voltage select |

## Verification
A pad level change and a bus write to the output data register can land on the same clock edge. Only the pad change may reach the mirror. The bench makes both changes on the same falling edge: it drives new pad levels and writes a different pattern to offset 0. It then reads the mirror after the first rising edge and expects the old pad value, and after the second rising edge expects the new pad value. At the same time it confirms that `pad_out` carries the newly written data.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int BYTE_W     = 8;
    localparam int OFF_DATA   = 0;
    localparam int OFF_MIRROR = 1;
    localparam int OFF_OTYPE  = 2;
    localparam int OFF_VSEL   = 3;

    typedef struct packed {
        logic       tri_st;
        logic [2:0] rsvd;
        logic       pdn;
        logic       pup;
        logic       outm;
        logic       inm;
    } pin_ctrl_t;

    localparam pin_ctrl_t CTRL_RESET = '{tri_st: 1'b0, rsvd: 3'b000, pdn: 1'b0,
                                         pup: 1'b0, outm: 1'b0, inm: 1'b1};

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_MIRROR,
        SEL_OTYPE,
        SEL_VSEL,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_e;

    function automatic pin_ctrl_t sanitize_ctrl(input logic [BYTE_W-1:0] w,
                                                input logic tri_ok);
        pin_ctrl_t c;
        c = '0;
        if (w[7]) begin
            if (tri_ok) c.tri_st = 1'b1;
            else        c = CTRL_RESET;
        end else begin
            c.outm = w[1];
            c.inm  = w[0] & ~w[1];
            c.pup  = w[2];
            c.pdn  = w[3] & ~w[2];
        end
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_q
);
    logic [W-1:0] meta_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk) begin
        meta_q <= pad_in;
        sync_q <= meta_q;
    end

    // checker-only counter: cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R3: two-edge latency from pad to synchronized value
    p_sync_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (sync_q == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_port_pkg::*;
#(
    parameter logic TRI_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              data_bit,
    input  logic              od_bit,
    output pin_ctrl_t         ctrl_q,
    output logic              pad_oe,
    output logic              pad_out,
    output logic              pad_pu,
    output logic              pad_pd
);
    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= CTRL_RESET;
        else if (wr_ctrl) ctrl_q <= sanitize_ctrl(wdata, TRI_OK);
    end

    always_comb begin
        pad_out = data_bit & ~od_bit;
        pad_oe  = ctrl_q.outm & (~od_bit | ~data_bit);
        pad_pu  = ctrl_q.pup;
        pad_pd  = ctrl_q.pdn;
    end

    p_mode_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.outm && ctrl_q.inm));

    p_pull_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.pup && ctrl_q.pdn));

    p_tri_rejected_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[7] && !TRI_OK) |=> (ctrl_q == CTRL_RESET));

    p_tri_clean_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.tri_st |-> (!pad_oe && !pad_pu && !pad_pd));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter logic [NPINS-1:0] TRI_CAP  = 8'h0F,
    parameter logic [NPINS-1:0] VSEL_CAP = 8'hF0,
    parameter int               ADDR_W   = $clog2(NPINS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  pad_lowv
);
    localparam int IDX_W     = ADDR_W - 1;
    localparam int CTRL_BASE = 1 << IDX_W;

    logic [NPINS-1:0] data_q, od_q, vsel_q, mirror_q;
    pin_ctrl_t        ctrl_q [NPINS];
    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;

    assign idx = addr[IDX_W-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1]) begin
            if (int'(idx) < NPINS) sel = SEL_CTRL;
        end else begin
            case (addr)
                ADDR_W'(OFF_DATA):   sel = SEL_DATA;
                ADDR_W'(OFF_MIRROR): sel = SEL_MIRROR;
                ADDR_W'(OFF_OTYPE):  sel = SEL_OTYPE;
                ADDR_W'(OFF_VSEL):   sel = SEL_VSEL;
                default:             sel = SEL_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            od_q   <= '0;
            vsel_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA:  data_q <= wdata[NPINS-1:0];
                SEL_OTYPE: od_q   <= wdata[NPINS-1:0];
                SEL_VSEL:  vsel_q <= wdata[NPINS-1:0] & VSEL_CAP;
                default: ;
            endcase
        end
    end

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .sync_q (mirror_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_slice #(.TRI_OK(TRI_CAP[i])) u_slice (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (wr_en && (addr == ADDR_W'(CTRL_BASE + i))),
            .wdata    (wdata),
            .data_bit (data_q[i]),
            .od_bit   (od_q[i]),
            .ctrl_q   (ctrl_q[i]),
            .pad_oe   (pad_oe[i]),
            .pad_out  (pad_out[i]),
            .pad_pu   (pad_pu[i]),
            .pad_pd   (pad_pd[i])
        );
    end

    assign pad_lowv = vsel_q;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DATA:   rdata[NPINS-1:0] = data_q;
            SEL_MIRROR: rdata[NPINS-1:0] = mirror_q;
            SEL_OTYPE:  rdata[NPINS-1:0] = od_q;
            SEL_VSEL:   rdata[NPINS-1:0] = vsel_q;
            SEL_CTRL:   rdata = ctrl_q[idx];
            default:    rdata = '0;
        endcase
    end

    p_ro_mirror_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_MIRROR || sel == SEL_NONE))
        |=> ($stable(data_q) && $stable(od_q) && $stable(vsel_q)));

    p_vsel_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (pad_lowv & ~VSEL_CAP) == '0);

    p_od_sink_only_r4: assert property (@(posedge clk) disable iff (rst)
        ((od_q & pad_out) == '0));

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pad_in = 8'hA5;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_pd, pad_lowv;

    always #5 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_lowv(pad_lowv)
    );

    localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PU = 3, K_PD = 4, K_LV = 5;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic [7:0] observe(int kind);
        case (kind)
            K_RD:    return rdata;
            K_OE:    return pad_oe;
            K_OUT:   return pad_out;
            K_PU:    return pad_pu;
            K_PD:    return pad_pd;
            default: return pad_lowv;
        endcase
    endfunction

    // monitor: compares everything queued for this low phase
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [7:0] act;
                it  = exp_q.pop_front();
                act = observe(it.kind);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_pad(int kind, logic [7:0] e, string tag);
        exp_item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
        addr = a;
        expect_pad(K_RD, e, tag);
        step();
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step();
        repeat (4) step();
        rst = 1'b0;
        step();

        // R1 reset values
        expect_pad(K_OE, 8'h00, "R1 oe after reset");
        rd(4'd0, 8'h00, "R1 data reset");
        rd(4'd2, 8'h00, "R1 otype reset");
        rd(4'd3, 8'h00, "R1 vsel reset");
        rd(4'd8, 8'h01, "R1 ctrl0 reset");
        rd(4'd15, 8'h01, "R1 ctrl7 reset");
        rd(4'd1, 8'hA5, "R3 mirror after reset");

        // R9 unmapped reads
        rd(4'd4, 8'h00, "R9 unmapped 4");
        rd(4'd7, 8'h00, "R9 unmapped 7");

        // R7 preset while input, R2 readback
        wr(4'd0, 8'h3C);
        expect_pad(K_OE, 8'h00, "R7 no drive while input");
        rd(4'd0, 8'h3C, "R2 data readback");
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'h02);
        expect_pad(K_OE, 8'hFF, "R7 drive after mode change");
        expect_pad(K_OUT, 8'h3C, "R7 preset level");
        rd(4'd8, 8'h02, "R2 ctrl output mode");

        // R3 pad change and data write on the same edge
        pad_in = 8'h5A; wr_en = 1'b1; addr = 4'd0; wdata = 8'hFF;
        step();
        wr_en = 1'b0;
        rd(4'd1, 8'hA5, "R3 mirror one edge later still old");
        expect_pad(K_OUT, 8'hFF, "R2 out follows new data");
        rd(4'd1, 8'h5A, "R3 mirror two edges later shows pad");

        // R4 open drain on pins 0..3
        wr(4'd2, 8'h0F);
        expect_pad(K_OE, 8'hF0, "R4 released when data 1");
        expect_pad(K_OUT, 8'hF0, "R4 sink only");
        step();
        wr(4'd0, 8'hAA);
        expect_pad(K_OE, 8'hF5, "R4 sink when data 0");
        expect_pad(K_OUT, 8'hA0, "R4 out low on od pins");
        rd(4'd2, 8'h0F, "R4 otype readback");

        // R5 encoding and exclusivity, R10 pulls
        wr(4'd8, 8'h03);
        rd(4'd8, 8'h02, "R5 output wins");
        wr(4'd9, 8'h0C);
        rd(4'd9, 8'h04, "R5 pull-up wins");
        wr(4'd10, 8'h79);
        rd(4'd10, 8'h09, "R5 reserved bits dropped");
        expect_pad(K_PU, 8'h02, "R10 pull-up pin1");
        expect_pad(K_PD, 8'h04, "R10 pull-down pin2");
        step();

        // R6 tri-state
        wr(4'd11, 8'h80);
        rd(4'd11, 8'h80, "R6 tri on capable pin3");
        wr(4'd12, 8'h80);
        rd(4'd12, 8'h01, "R6 tri refused pin4");
        wr(4'd13, 8'h8E);
        rd(4'd13, 8'h01, "R6 tri refused pin5");
        wr(4'd8, 8'h84);
        rd(4'd8, 8'h80, "R6 tri pin0 drops pull");
        expect_pad(K_OE, 8'hC0, "R6 tri pins not driven");
        expect_pad(K_PU, 8'h02, "R6 no pull on tri pin0");
        step();

        // R8 voltage select
        wr(4'd3, 8'hFF);
        expect_pad(K_LV, 8'hF0, "R8 lowv capable only");
        rd(4'd3, 8'hF0, "R8 vsel masked");
        wr(4'd3, 8'h30);
        rd(4'd3, 8'h30, "R8 vsel readback");

        // R9 ignored writes
        wr(4'd1, 8'h00);
        rd(4'd0, 8'hAA, "R9 mirror write data kept");
        rd(4'd2, 8'h0F, "R9 mirror write otype kept");
        rd(4'd1, 8'h5A, "R9 mirror still pad");
        wr(4'd5, 8'hFF);
        rd(4'd5, 8'h00, "R9 unmapped after write");
        rd(4'd3, 8'h30, "R9 vsel kept");
        rd(4'd0, 8'hAA, "R9 data kept");

        // R1 reset mid-run
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        rd(4'd11, 8'h01, "R1 ctrl back to input");
        rd(4'd0, 8'h00, "R1 data cleared");
        expect_pad(K_LV, 8'h00, "R1 lowv cleared");
        step();

        step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule